// File: doc/BRIEF.md
# Command Packet FIFO Interface

This block sits between a host register port and the packet layer of a serial display link. Software queues the payload words of a long packet into a write payload FIFO, then writes a 32-bit header word into a command FIFO. Writing the header is what launches the packet. A transmit engine sends the header word over a valid/ready handshake and, for long packets, follows it with as many payload words as the header's word count requires. Short packets carry their parameters inside the header and send no payload.

Read-type headers put the block in a read phase, marked by a busy flag. Response bytes come back from the link one at a time. The block packs them lowest byte first into 32-bit words and pushes them into a read payload FIFO, where the host drains them. A status register reports, for each FIFO, whether it is empty or full. It also reports the busy flag and a sticky overflow flag. The host knows a transfer has finished once the command FIFO and the write payload FIFO both read as empty. ECC, checksums and physical signalling belong to other blocks.

Register word addresses on `reg_addr_i`: 0 is control, 1 is header (write only), 2 is payload (a write pushes to the write payload FIFO, a read pops from the read payload FIFO), and 3 is status.

Top module: `cmd_pkt_if`

## Requirements
- R1: Status bit positions are: bit0 command FIFO empty, bit1 command FIFO full, bit2 write payload empty, bit3 write payload full, bit4 read payload empty, bit5 read payload full, bit6 read busy, bit8 sticky overflow. After reset the status reads 0x15.
- R2: Once a header word is queued and no read is busy, the block offers it on `tx_data_o` with `tx_hdr_o`=1. On that header beat `tx_ack_req_o` equals control bit1. Payload beats carry `tx_hdr_o`=0 and `tx_ack_req_o`=0.
- R3: The data type is header bits 5:0 and the word count is header bits 23:8. Data types 0x29 and 0x39 are long packets, and each sends ceil(count/4) payload words after its header, in the order they were written. Every other type, and a long packet with a count of 0, sends only the header.
- R4: While `tx_valid_o` is 1 and `tx_ready_i` is 0, `tx_valid_o` stays 1 and `tx_data_o` stays unchanged on the next cycle.
- R5: During a long packet, `tx_valid_o` stays 0 while the write payload FIFO is empty, and the remaining words are sent once they arrive.
- R6: Data types 0x04, 0x14, 0x24 and 0x06 are reads. When a read header is accepted, read busy is set. No further header is offered while read busy is set. Read busy clears on the clock after a received byte that has `rx_last_i`=1.
- R7: Received bytes are packed lowest byte first into bits 7:0, 15:8, 23:16 and 31:24. A word is pushed when it holds four bytes or when the last byte arrives, and a partial final word is padded with zeros.
- R8: Reading the payload address returns the head of the read payload FIFO and pops it. If that FIFO is empty, the read returns 0.
- R9: A write to the header or payload address while its FIFO is full is dropped, as is a received word while the read FIFO is full. Either case sets the sticky overflow bit. Writing status with bit8=1 clears it.
- R10: Only control bits 1, 8-14, 16-19 and 24 can be written (mask 0x010F7F02). All other control bits read 0.
- R11: Each FIFO holds DEPTH (default 16) words. It reports full after DEPTH writes with no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_valid_o | output | 1 | Transmit word valid |
| tx_ready_i | input | 1 | Link accepts the transmit word |
| tx_data_o | output | 32 | Transmit word |
| tx_hdr_o | output | 1 | Transmit word is a header |
| tx_ack_req_o | output | 1 | Acknowledge requested for this header |
| rx_valid_i | input | 1 | Response byte valid |
| rx_byte_i | input | 8 | Response byte |
| rx_last_i | input | 1 | Last byte of the response |

## Verification
Register reads are combinational, so a read issued after the clock edge that completed a write already shows the new state. A header written at edge N can be offered on the link in the cycle right after edge N, and each following word is offered in the cycle after the previous word was accepted. The scoreboard therefore checks beats in order as they occur rather than at fixed times, and it samples valid and ready just before each edge. Busy sets at the edge that accepts a read header, and it clears, together with the push of the final response word, at the edge that takes the last byte. Status and payload reads are issued only after those edges.

// File: rtl/cmd_pkt_pkg.sv
`timescale 1ns/1ps
package cmd_pkt_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_HDR  = 2'd1;
  localparam logic [1:0] A_PLD  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int ST_CMD_EMPTY = 0;
  localparam int ST_CMD_FULL  = 1;
  localparam int ST_WPL_EMPTY = 2;
  localparam int ST_WPL_FULL  = 3;
  localparam int ST_RPL_EMPTY = 4;
  localparam int ST_RPL_FULL  = 5;
  localparam int ST_RD_BUSY   = 6;
  localparam int ST_OVF       = 8;

  localparam logic [31:0] CTRL_MASK = 32'h010F_7F02;
  localparam int CTRL_ACK = 1;

  function automatic logic is_long(input logic [5:0] dt);
    return (dt == 6'h29) || (dt == 6'h39);
  endfunction

  function automatic logic is_read(input logic [5:0] dt);
    return (dt == 6'h04) || (dt == 6'h14) || (dt == 6'h24) || (dt == 6'h06);
  endfunction
endpackage

// File: rtl/cmd_pkt_fifo.sv
`timescale 1ns/1ps
module cmd_pkt_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assert_full_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (full_o && $stable(cnt_q)));
  assert_fill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> !empty_o);
endmodule

// File: rtl/cmd_pkt_tx.sv
`timescale 1ns/1ps
module cmd_pkt_tx
  import cmd_pkt_pkg::*;
#(
  parameter int W    = 32,
  parameter int WC_W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cmd_head_i,
  input  logic         cmd_empty_i,
  output logic         cmd_pop_o,
  input  logic [W-1:0] pld_head_i,
  input  logic         pld_empty_i,
  output logic         pld_pop_o,
  input  logic         busy_i,
  input  logic         ack_en_i,
  input  logic         tx_ready_i,
  output logic         tx_valid_o,
  output logic [W-1:0] tx_data_o,
  output logic         tx_hdr_o,
  output logic         tx_ack_o,
  output logic         launch_rd_o
);
  localparam int CNT_W = WC_W - 1;

  typedef enum logic {S_HDR, S_PLD} st_e;
  st_e st_q;
  logic [CNT_W-1:0] left_q;

  logic [5:0]      dt;
  logic [WC_W-1:0] wc;
  logic [WC_W:0]   wsum;
  logic [CNT_W-1:0] nwords;
  logic fire;

  assign dt     = cmd_head_i[5:0];
  assign wc     = cmd_head_i[8 +: WC_W];
  assign wsum   = {1'b0, wc} + (WC_W+1)'(3);
  assign nwords = wsum[WC_W:2];

  always_comb begin
    tx_hdr_o   = (st_q == S_HDR);
    tx_valid_o = tx_hdr_o ? (!cmd_empty_i && !busy_i) : !pld_empty_i;
    tx_data_o  = tx_hdr_o ? cmd_head_i : pld_head_i;
    tx_ack_o   = tx_hdr_o && ack_en_i;
  end

  assign fire        = tx_valid_o && tx_ready_i;
  assign cmd_pop_o   = fire && tx_hdr_o;
  assign pld_pop_o   = fire && !tx_hdr_o;
  assign launch_rd_o = cmd_pop_o && is_read(dt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_HDR;
      left_q <= '0;
    end else if (cmd_pop_o) begin
      if (is_long(dt) && (nwords != '0)) begin
        st_q   <= S_PLD;
        left_q <= nwords;
      end
    end else if (pld_pop_o) begin
      left_q <= left_q - 1'b1;
      if (left_q == CNT_W'(1)) st_q <= S_HDR;
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_pld_left_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PLD) |-> (left_q != '0));
  assert_busy_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && tx_hdr_o) |-> !cmd_pop_o);
endmodule

// File: rtl/cmd_pkt_rx.sv
`timescale 1ns/1ps
module cmd_pkt_rx #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_valid_i,
  input  logic [7:0]   rx_byte_i,
  input  logic         rx_last_i,
  input  logic         launch_i,
  output logic         push_o,
  output logic [W-1:0] word_o,
  output logic         busy_o
);
  localparam int NB = W / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [W-1:0]  acc_q;
  logic [IW-1:0] idx_q;

  always_comb begin
    word_o = acc_q;
    for (int b = 0; b < NB; b++) begin
      if (idx_q == IW'(b)) word_o[b*8 +: 8] = rx_byte_i;
    end
  end

  assign push_o = rx_valid_i && ((idx_q == IW'(NB - 1)) || rx_last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      idx_q  <= '0;
      busy_o <= 1'b0;
    end else begin
      if (rx_valid_i) begin
        if (push_o) begin
          acc_q <= '0;
          idx_q <= '0;
        end else begin
          acc_q <= word_o;
          idx_q <= idx_q + 1'b1;
        end
      end
      if (launch_i)                     busy_o <= 1'b1;
      else if (rx_valid_i && rx_last_i) busy_o <= 1'b0;
    end
  end

  assert_busy_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o);
  assert_busy_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_last_i && !launch_i) |=> !busy_o);
  assert_pack_reset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> (idx_q == '0));
endmodule

// File: rtl/cmd_pkt_if.sv
`timescale 1ns/1ps
module cmd_pkt_if
  import cmd_pkt_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_re_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [31:0] tx_data_o,
  output logic        tx_hdr_o,
  output logic        tx_ack_req_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        rx_last_i
);
  localparam int W = 32;

  logic [W-1:0] ctrl_q;
  logic         ovf_q;

  logic cmd_push, cmd_pop, cmd_empty, cmd_full;
  logic wpl_push, wpl_pop, wpl_empty, wpl_full;
  logic rpl_push, rpl_pop, rpl_empty, rpl_full;
  logic [W-1:0] cmd_head, wpl_head, rpl_head, rx_word;
  logic rd_busy, launch_rd;
  logic ovf_set, ovf_clr;
  logic [W-1:0] status;

  assign cmd_push = reg_we_i && (reg_addr_i == A_HDR);
  assign wpl_push = reg_we_i && (reg_addr_i == A_PLD);
  assign rpl_pop  = reg_re_i && (reg_addr_i == A_PLD);

  cmd_pkt_fifo #(.W(W), .DEPTH(DEPTH)) u_cmd_fifo (
    .clk_i, .rst_ni, .push_i(cmd_push), .pop_i(cmd_pop), .wdata_i(reg_wdata_i),
    .rdata_o(cmd_head), .empty_o(cmd_empty), .full_o(cmd_full));

  cmd_pkt_fifo #(.W(W), .DEPTH(DEPTH)) u_wpl_fifo (
    .clk_i, .rst_ni, .push_i(wpl_push), .pop_i(wpl_pop), .wdata_i(reg_wdata_i),
    .rdata_o(wpl_head), .empty_o(wpl_empty), .full_o(wpl_full));

  cmd_pkt_fifo #(.W(W), .DEPTH(DEPTH)) u_rpl_fifo (
    .clk_i, .rst_ni, .push_i(rpl_push), .pop_i(rpl_pop), .wdata_i(rx_word),
    .rdata_o(rpl_head), .empty_o(rpl_empty), .full_o(rpl_full));

  cmd_pkt_tx #(.W(W), .WC_W(16)) u_tx (
    .clk_i, .rst_ni,
    .cmd_head_i(cmd_head), .cmd_empty_i(cmd_empty), .cmd_pop_o(cmd_pop),
    .pld_head_i(wpl_head), .pld_empty_i(wpl_empty), .pld_pop_o(wpl_pop),
    .busy_i(rd_busy), .ack_en_i(ctrl_q[CTRL_ACK]), .tx_ready_i,
    .tx_valid_o, .tx_data_o, .tx_hdr_o, .tx_ack_o(tx_ack_req_o),
    .launch_rd_o(launch_rd));

  cmd_pkt_rx #(.W(W)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_byte_i, .rx_last_i,
    .launch_i(launch_rd), .push_o(rpl_push), .word_o(rx_word), .busy_o(rd_busy));

  assign ovf_set = (cmd_push && cmd_full) || (wpl_push && wpl_full) || (rpl_push && rpl_full);
  assign ovf_clr = reg_we_i && (reg_addr_i == A_STAT) && reg_wdata_i[ST_OVF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (reg_we_i && (reg_addr_i == A_CTRL)) ctrl_q <= reg_wdata_i & CTRL_MASK;
      if (ovf_set)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    status[ST_CMD_EMPTY] = cmd_empty;
    status[ST_CMD_FULL]  = cmd_full;
    status[ST_WPL_EMPTY] = wpl_empty;
    status[ST_WPL_FULL]  = wpl_full;
    status[ST_RPL_EMPTY] = rpl_empty;
    status[ST_RPL_FULL]  = rpl_full;
    status[ST_RD_BUSY]   = rd_busy;
    status[ST_OVF]       = ovf_q;
    case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_PLD:   reg_rdata_o = rpl_empty ? '0 : rpl_head;
      A_STAT:  reg_rdata_o = status;
      default: reg_rdata_o = '0;
    endcase
  end

  assert_flags_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_empty && cmd_full) && !(wpl_empty && wpl_full) && !(rpl_empty && rpl_full));
  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_ovf_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wpl_push && wpl_full) |=> ovf_q);
endmodule

// File: tb/cmd_pkt_if_bench.sv
`timescale 1ns/100ps
module cmd_pkt_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid, tx_ready, tx_hdr, tx_ack;
  logic [31:0] tx_data;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_byte = '0;

  int vectors = 0;
  int errors = 0;
  logic [33:0] exp_q[$];
  logic ack_exp = 1'b0;
  logic stall_en = 1'b0, hold_low = 1'b0;
  logic [3:0] lfsr = 4'h9;

  always #2.5 clk = ~clk;

  cmd_pkt_if u_cmd_pkt_if (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_re_i(reg_re),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .tx_hdr_o(tx_hdr), .tx_ack_req_o(tx_ack),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .rx_last_i(rx_last));

  initial tx_ready = 1'b1;
  always @(negedge clk) begin
    lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
    tx_ready <= hold_low ? 1'b0 : (stall_en ? lfsr[0] : 1'b1);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor: beat taken at the coming edge (R2, R3, R4)
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && tx_valid && tx_ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R3/R4 unexpected beat: actual %h expected none", {tx_hdr, tx_ack, tx_data});
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        if ({tx_hdr, tx_ack, tx_data} !== e) begin
          errors++;
          $display("FAIL R2/R3/R4 beat: actual %h expected %h", {tx_hdr, tx_ack, tx_data}, e);
        end
      end
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b, input logic last);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b; rx_last = last;
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic expect_beat(input logic h, input logic a, input logic [31:0] d);
    exp_q.push_back({h, a, d});
  endtask

  task automatic wait_drain();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      reg_rd(2'd3, s);
      if (exp_q.size() == 0 && s[0] && s[2]) break;
    end
  endtask

  task automatic send_long(input logic [5:0] dt, input int n, input logic [7:0] seed);
    logic [31:0] w;
    expect_beat(1'b1, ack_exp, {8'h00, 16'(n), 2'b00, dt});
    for (int i = 0; i < (n + 3) / 4; i++) begin
      w = '0;
      for (int b = 0; b < 4; b++)
        if (i * 4 + b < n) w[b*8 +: 8] = seed + 8'(i * 4 + b);
      expect_beat(1'b0, 1'b0, w);
      reg_wr(2'd2, w);
    end
    reg_wr(2'd1, {8'h00, 16'(n), 2'b00, dt});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reg_rd(2'd3, r); check("R1 reset status", r, 32'h15);
    reg_rd(2'd0, r); check("R10 reset ctrl", r, 32'h0);
    reg_rd(2'd2, r); check("R8 empty read", r, 32'h0);

    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, r); check("R10 ctrl mask", r, 32'h010F_7F02);
    ack_exp = 1'b1;

    // R2 short packet with ack request
    expect_beat(1'b1, 1'b1, 32'h00AB_1505);
    reg_wr(2'd1, 32'h00AB_1505);
    wait_drain();

    reg_wr(2'd0, 32'h0);
    reg_rd(2'd0, r); check("R10 ctrl clear", r, 32'h0);
    ack_exp = 1'b0;

    // R3 long packet, 6 bytes, random backpressure
    stall_en = 1'b1;
    send_long(6'h39, 6, 8'hA0);
    wait_drain();
    // R3 long with zero count: header only
    send_long(6'h29, 0, 8'h00);
    wait_drain();
    stall_en = 1'b0;
    reg_rd(2'd3, r); check("R1 done flags", r, 32'h15);

    // R5 header before payload
    expect_beat(1'b1, 1'b0, 32'h0000_0829);
    expect_beat(1'b0, 1'b0, 32'h1111_1111);
    expect_beat(1'b0, 1'b0, 32'h2222_2222);
    reg_wr(2'd1, 32'h0000_0829);
    repeat (8) @(negedge clk);
    #1 check("R5 stalled valid", {31'b0, tx_valid}, 32'h0);
    reg_wr(2'd2, 32'h1111_1111);
    reg_wr(2'd2, 32'h2222_2222);
    wait_drain();

    // R4 hold under backpressure
    hold_low = 1'b1;
    expect_beat(1'b1, 1'b0, 32'h0000_7715);
    reg_wr(2'd1, 32'h0000_7715);
    repeat (3) @(negedge clk);
    #1 check("R4 valid held", {31'b0, tx_valid}, 32'h1);
    check("R4 data held", tx_data, 32'h0000_7715);
    @(negedge clk);
    #1 check("R4 data stable", tx_data, 32'h0000_7715);
    hold_low = 1'b0;
    wait_drain();

    // R6 read phase blocks the next header
    expect_beat(1'b1, 1'b0, 32'h0000_0A06);
    reg_wr(2'd1, 32'h0000_0A06);
    wait_drain();
    reg_rd(2'd3, r); check("R6 busy set", r, 32'h55);
    expect_beat(1'b1, 1'b0, 32'h0000_3405);
    reg_wr(2'd1, 32'h0000_3405);
    repeat (6) @(negedge clk);
    #1 check("R6 header blocked", {31'b0, tx_valid}, 32'h0);
    reg_rd(2'd3, r); check("R6 cmd queued", r, 32'h54);
    rx_put(8'h11, 1'b0);
    rx_put(8'h22, 1'b0);
    rx_put(8'h33, 1'b0);
    rx_put(8'h44, 1'b0);
    rx_put(8'h55, 1'b1);
    wait_drain();
    reg_rd(2'd3, r); check("R6 busy cleared", r, 32'h05);
    reg_rd(2'd2, r); check("R7 full word", r, 32'h4433_2211);
    reg_rd(2'd2, r); check("R7 padded word", r, 32'h0000_0055);
    reg_rd(2'd2, r); check("R8 empty returns 0", r, 32'h0);
    reg_rd(2'd3, r); check("R8 drained", r, 32'h15);

    // R11 fill, R9 drop and sticky flag
    for (int i = 0; i < 16; i++) reg_wr(2'd2, 32'h1000 + i);
    reg_rd(2'd3, r); check("R11 full", r, 32'h19);
    reg_wr(2'd2, 32'hDEAD_BEEF);
    reg_rd(2'd3, r); check("R9 overflow", r, 32'h119);
    reg_rd(2'd3, r); check("R9 sticky", r, 32'h119);
    reg_wr(2'd3, 32'h100);
    reg_rd(2'd3, r); check("R9 clear", r, 32'h19);
    expect_beat(1'b1, 1'b0, 32'h0000_4029);
    for (int i = 0; i < 16; i++) expect_beat(1'b0, 1'b0, 32'h1000 + i);
    reg_wr(2'd1, 32'h0000_4029);
    wait_drain();
    reg_rd(2'd3, r); check("R9 drained", r, 32'h15);

    check("R2 scoreboard empty", exp_q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule